// File: doc/BRIEF.md
# Expanding opcode instruction decoder

This block classifies 16-bit instruction words in which the opcode field gets longer as the number of register operands gets smaller. A short opcode leaves room for three 4-bit register selectors. Longer opcodes are reached through all-ones escape values at the top of each level, and each longer opcode carries one fewer selector. At the deepest level the whole word is opcode. Every one of the 65536 words decodes to exactly one instruction: 15 with three operands, 14 with two, 31 with one and 16 with none.

For each word presented with a valid strobe, the decoder reports the operand class and a dense opcode index that counts from zero within that class. It also reports the register selectors that apply and drives the unused ones to zero. All results sit in a single pipeline register, so they appear one clock after the strobe. The block does not execute instructions and does not fetch anything.

Top module: `eod_decoder`

## Requirements
- R1: When bits [15:12] of the word are not 0xF, the class code is 2'b00 (three operands), the index is bits [15:12], and ra, rb and rc carry bits [11:8], [7:4] and [3:0].
- R2: When bits [15:8] lie in 0xF0 to 0xFD, the class code is 2'b01 (two operands), the index is bits [11:8], ra carries bits [7:4], rb carries bits [3:0], and rc is zero.
- R3: When bits [15:4] lie in 0xFE0 to 0xFFE, the class code is 2'b10 (one operand), the index is bits [15:4] minus 0xFE0 (0 to 30), ra carries bits [3:0], and rb and rc are zero.
- R4: When bits [15:4] equal 0xFFF, the class code is 2'b11 (no operands), the index is bits [3:0], and ra, rb and rc are all zero.
- R5: Across all 65536 words, the number of distinct index values seen per class is exactly 15, 14, 31 and 16 for classes 2'b00, 2'b01, 2'b10 and 2'b11.
- R6: The decoded results for a word appear on the outputs at the first rising edge after the strobe is sampled high, and out_valid equals in_valid delayed by one cycle.
- R7: While in_valid is low, out_class, out_index, out_ra, out_rb and out_rc keep the values they had, whatever in_word carries.
- R8: A synchronous active-high reset clears out_valid and drives the class, index and register outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking in_word as a word to decode |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Strobe delayed by one cycle |
| out_class | output | 2 | Operand class: 00 three, 01 two, 10 one, 11 none |
| out_index | output | 5 | Opcode index within the class |
| out_ra | output | 4 | First register selector, zero if unused |
| out_rb | output | 4 | Second register selector, zero if unused |
| out_rc | output | 4 | Third register selector, zero if unused |

## Verification
Every result of this block, including the class, index, selectors and out_valid, is due exactly one rising edge after the word and strobe are sampled. The bench drives each word on a falling edge. On the next falling edge, one edge after the capture, it compares all outputs with the expected value that its own model built from the word it drove. After a low strobe, the expected outputs are the previous ones, which covers the hold rule at the same point. After a reset, the zero state is checked on the falling edge that follows the reset edge.

// File: rtl/eod_pkg.sv
package eod_pkg;
    localparam int REG_W   = 4;
    localparam int N_FLD   = 4;
    localparam int INSN_W  = REG_W * N_FLD;
    localparam int IDX_W   = REG_W + 1;
    localparam int CLS_W   = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_TRI = 2'b00,
        CLS_DUO = 2'b01,
        CLS_UNO = 2'b10,
        CLS_NIL = 2'b11
    } opclass_e;

    typedef logic [REG_W-1:0] reg_sel_t;

    typedef struct packed {
        opclass_e          cls;
        logic [IDX_W-1:0]  idx;
        reg_sel_t          ra;
        reg_sel_t          rb;
        reg_sel_t          rc;
    } dec_t;

    function automatic logic fld_all_ones(input reg_sel_t f);
        return &f;
    endfunction

    function automatic logic fld_is_escape2(input reg_sel_t f);
        return &f[REG_W-1:1];
    endfunction
endpackage

// File: rtl/eod_split.sv
module eod_split
    import eod_pkg::*;
(
    input  logic [INSN_W-1:0]           word,
    output logic [N_FLD-1:0][REG_W-1:0] fld
);
    for (genvar gi = 0; gi < N_FLD; gi++) begin : g_fld
        assign fld[gi] = word[gi*REG_W +: REG_W];
    end
endmodule

// File: rtl/eod_classify.sv
module eod_classify
    import eod_pkg::*;
(
    input  logic [N_FLD-1:0][REG_W-1:0] fld,
    output dec_t                        dec
);
    logic top_esc, mid_esc, deep_esc;

    always_comb begin
        top_esc  = fld_all_ones(fld[3]);
        mid_esc  = fld_is_escape2(fld[2]);
        deep_esc = fld_all_ones(fld[2]) && fld_all_ones(fld[1]);
        dec      = '0;
        if (!top_esc) begin
            dec.cls = CLS_TRI;
            dec.idx = {1'b0, fld[3]};
            dec.ra  = fld[2];
            dec.rb  = fld[1];
            dec.rc  = fld[0];
        end else if (!mid_esc) begin
            dec.cls = CLS_DUO;
            dec.idx = {1'b0, fld[2]};
            dec.ra  = fld[1];
            dec.rb  = fld[0];
        end else if (!deep_esc) begin
            dec.cls = CLS_UNO;
            dec.idx = {fld[2][0], fld[1]};
            dec.ra  = fld[0];
        end else begin
            dec.cls = CLS_NIL;
            dec.idx = {1'b0, fld[0]};
        end
    end

    // R5: each class keeps its index inside its own count
    always_comb begin
        assert_tri_range_R5: assert (dec.cls != CLS_TRI || dec.idx < IDX_W'(15));
        assert_duo_range_R5: assert (dec.cls != CLS_DUO || dec.idx < IDX_W'(14));
        assert_uno_range_R5: assert (dec.cls != CLS_UNO || dec.idx < IDX_W'(31));
    end
endmodule

// File: rtl/eod_stage.sv
module eod_stage
    import eod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  dec_t d,
    output logic q_valid,
    output dec_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) q <= d;
        end
    end
endmodule

// File: rtl/eod_decoder.sv
module eod_decoder
    import eod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [15:0]       in_word,
    output logic              out_valid,
    output logic [1:0]        out_class,
    output logic [4:0]        out_index,
    output logic [3:0]        out_ra,
    output logic [3:0]        out_rb,
    output logic [3:0]        out_rc
);
    logic [N_FLD-1:0][REG_W-1:0] fld;
    dec_t dec_c, dec_q;

    eod_split u_split (
        .word (in_word),
        .fld  (fld)
    );

    eod_classify u_class (
        .fld (fld),
        .dec (dec_c)
    );

    eod_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (dec_c),
        .q_valid  (out_valid),
        .q        (dec_q)
    );

    assign out_class = dec_q.cls;
    assign out_index = dec_q.idx;
    assign out_ra    = dec_q.ra;
    assign out_rb    = dec_q.rb;
    assign out_rc    = dec_q.rc;

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_low_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_class) && $stable(out_index) &&
                       $stable(out_ra) && $stable(out_rb) && $stable(out_rc)));
    assert_tri_class_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[15:12] != 4'hF) |=> (out_class == 2'b00));
    assert_nil_regs_R4: assert property (@(posedge clk) disable iff (rst)
        (out_class == 2'b11) |-> (out_ra == '0 && out_rb == '0 && out_rc == '0));
    assert_uno_regs_R3: assert property (@(posedge clk) disable iff (rst)
        (out_class == 2'b10) |-> (out_rb == '0 && out_rc == '0));
    assert_duo_reg_R2: assert property (@(posedge clk) disable iff (rst)
        (out_class == 2'b01) |-> (out_rc == '0));
    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && out_class == 2'b00 && out_index == '0));
endmodule

// File: tb/eod_decoder_tb.sv
module eod_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_valid;
    logic [1:0]  out_class;
    logic [4:0]  out_index;
    logic [3:0]  out_ra, out_rb, out_rc;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic        exp_valid;
    logic [1:0]  exp_cls;
    logic [4:0]  exp_idx;
    logic [3:0]  exp_ra, exp_rb, exp_rc;
    bit          prev_strobe;
    bit          seen [4][32];

    eod_decoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_class(out_class), .out_index(out_index),
        .out_ra(out_ra), .out_rb(out_rb), .out_rc(out_rc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model written straight from R1..R4
    task automatic model(input logic [15:0] w);
        exp_ra = '0; exp_rb = '0; exp_rc = '0;
        if (w[15:12] != 4'hF) begin
            exp_cls = 2'b00; exp_idx = {1'b0, w[15:12]};
            exp_ra = w[11:8]; exp_rb = w[7:4]; exp_rc = w[3:0];
        end else if (w[15:8] <= 8'hFD) begin
            exp_cls = 2'b01; exp_idx = {1'b0, w[11:8]};
            exp_ra = w[7:4]; exp_rb = w[3:0];
        end else if (w[15:4] != 12'hFFF) begin
            exp_cls = 2'b10; exp_idx = 5'(w[15:4] - 12'hFE0);
            exp_ra = w[3:0];
        end else begin
            exp_cls = 2'b11; exp_idx = {1'b0, w[3:0]};
        end
    endtask

    function automatic string cls_tag(input logic [1:0] c);
        case (c)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic compare(input string tag_override);
        string tag;
        n_checks++;
        if (out_valid !== exp_valid) begin
            n_fail++;
            $display("FAIL R6 valid: actual %0b expected %0b", out_valid, exp_valid);
        end
        tag = (tag_override != "") ? tag_override : cls_tag(exp_cls);
        n_checks++;
        if ({out_class, out_index, out_ra, out_rb, out_rc} !==
            {exp_cls, exp_idx, exp_ra, exp_rb, exp_rc}) begin
            n_fail++;
            $display("FAIL %s fields: actual cls=%0d idx=%0d ra=%h rb=%h rc=%h expected cls=%0d idx=%0d ra=%h rb=%h rc=%h",
                     tag, out_class, out_index, out_ra, out_rb, out_rc,
                     exp_cls, exp_idx, exp_ra, exp_rb, exp_rc);
        end
        if (out_valid === 1'b1) seen[out_class][out_index] = 1'b1;
    endtask

    // one cycle: check the result of the previous drive, then drive the next word
    task automatic step(input logic v, input logic [15:0] w);
        @(negedge clk);
        compare(prev_strobe ? "" : "R7");
        in_valid = v;
        in_word  = w;
        exp_valid = v;
        if (v) model(w);
        prev_strobe = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_word = 16'hFFFF;
        @(negedge clk);
        exp_valid = 1'b0; exp_cls = '0; exp_idx = '0;
        exp_ra = '0; exp_rb = '0; exp_rc = '0;
        compare("R8");
        rst = 1'b0;
        prev_strobe = 1'b0;
    endtask

    initial begin
        int cnt [4];
        int want [4];
        void'($urandom(32'h5EED_0D1E));
        prev_strobe = 1'b0;
        do_reset();

        // directed corners at every escape boundary
        step(1'b1, 16'hEABC);   // R1 last three-operand opcode
        step(1'b1, 16'hF0FF);   // R2 first two-operand opcode
        step(1'b1, 16'hFD12);   // R2 last
        step(1'b1, 16'hFE07);   // R3 index 0
        step(1'b1, 16'hFFE9);   // R3 index 30
        step(1'b1, 16'hFFF0);   // R4 index 0
        step(1'b1, 16'hFFFF);   // R4 index 15
        step(1'b0, 16'h1234);   // R7 ignored word
        step(1'b0, 16'hFFF3);   // R7 still held
        step(1'b1, 16'h0000);

        // exhaustive sweep, back to back
        for (int w = 0; w < 65536; w++) step(1'b1, 16'(w));
        step(1'b0, 16'h0);

        want = '{15, 14, 31, 16};
        for (int c = 0; c < 4; c++) begin
            cnt[c] = 0;
            for (int i = 0; i < 32; i++) if (seen[c][i]) cnt[c]++;
            n_checks++;
            if (cnt[c] != want[c]) begin
                n_fail++;
                $display("FAIL R5 class %0d distinct indices: actual %0d expected %0d",
                         c, cnt[c], want[c]);
            end
        end

        // random words with random strobe gaps (R6, R7)
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] rw;
            rw = 16'($urandom);
            if ($urandom_range(3) == 0) rw[15:8] = 8'hFF;
            step(($urandom_range(3) != 0), rw);
        end

        step(1'b1, 16'h7777);
        do_reset();             // R8 mid-run reset
        step(1'b0, 16'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYC);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule